// File: doc/BRIEF.md
# DMA Channel Control, Status and Interrupt Register Bank

This block is the software-visible control and status bank for a multi-channel DMA controller. Each channel owns one 32-bit word that mixes three kinds of bit: control bits that software writes (run, descriptor-less mode, stop-interrupt enable), live read-only state reported by the channel engine (request pending, stopped), and sticky event flags (descriptor end, descriptor start, bus error). Software clears a sticky flag by writing a one to it. Because all three kinds share one word, software can read a channel word and write the same value straight back. That write clears every flag that was pending and leaves the control bits as they were.

The channel engines report events as single-cycle pulses and report their state as levels. The bank turns these into one interrupt cause per channel. It shows the causes in a summary word with one bit per channel, and it drives a single combined interrupt line. A further word holds one bit per channel that permits byte-aligned addresses on that channel. Descriptor fetching and data movement happen elsewhere.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every control bit, sticky flag and alignment bit is 0, every register reads 0 and `irq_o` is low.
- R2: A write to channel word i (byte offset 4*i) loads bit 31 into run, bit 30 into descriptor-less mode and bit 29 into stop-interrupt enable. The new values are visible on `run_o[i]`, `nodesc_o[i]` and in readback from the next cycle.
- R3: A channel word reads request-pending (`eng_req[i]`) at bit 8 and stopped (`eng_stopped[i]`) at bit 3, both live. Bits 28..9 and 7..4 always read 0, whatever was written to them.
- R4: A pulse on `ev_end[i]`, `ev_start[i]` or `ev_berr[i]` sets the sticky flag at bit 2, bit 1 or bit 0 of channel word i. The flag stays set until software clears it.
- R5: Writing a one to bit 2, 1 or 0 clears that flag, and writing a zero leaves it alone. Writing a channel word back unchanged clears all pending flags and keeps the control bits.
- R6: When an event pulse and a clearing write to the same flag fall in the same cycle, the flag stays set.
- R7: The channel cause is active when one of these holds: the end flag is set and `desc_end_ie[i]` is 1; the start flag is set and `desc_start_ie[i]` is 1; the bus-error flag is set; or the channel is stopped and stop-interrupt enable is 1. The summary word at offset 0xF0 shows the cause of channel i at bit i. Writes to 0xF0 have no effect.
- R8: `irq_o` equals the OR of all summary bits as it stood one cycle earlier.
- R9: The alignment word at offset 0xA0 is read/write, with bit i driving `byte_align_o[i]`. Bits at and above NUM_CH read 0.
- R10: Any other address reads 0 and ignores writes. This covers channel slots at or beyond NUM_CH and offsets that are not multiples of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_start | input | NUM_CH | Descriptor-start event pulses |
| ev_end | input | NUM_CH | Descriptor-end event pulses |
| ev_berr | input | NUM_CH | Bus-error event pulses |
| desc_start_ie | input | NUM_CH | Per-descriptor start interrupt enables from the engines |
| desc_end_ie | input | NUM_CH | Per-descriptor end interrupt enables from the engines |
| eng_stopped | input | NUM_CH | Channel stopped state, level |
| eng_req | input | NUM_CH | Peripheral request pending, level |
| run_o | output | NUM_CH | Run control per channel |
| nodesc_o | output | NUM_CH | Descriptor-less mode per channel |
| byte_align_o | output | NUM_CH | Byte-alignment permission per channel |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
A write or an event pulse takes effect at the clock edge that samples it. Readback is combinational, so the new register value is due on `reg_rdata` at the falling edge after that clock edge. Live state bits and the summary word follow their inputs in the same cycle. `irq_o` lags the summary by exactly one more edge. The bench therefore drives every input on a falling edge and checks readback one falling edge after the sampling edge. It checks `irq_o` at both that falling edge and the next, so it sees the old value first and the new one after.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int BIT_RUN     = 31;
  localparam int BIT_NODESC  = 30;
  localparam int BIT_STOPIE  = 29;
  localparam int BIT_REQPEND = 8;
  localparam int BIT_STOPPED = 3;
  localparam int BIT_END     = 2;
  localparam int BIT_START   = 1;
  localparam int BIT_BERR    = 0;

  localparam logic [7:0] OFS_ALIGN   = 8'hA0;
  localparam logic [7:0] OFS_SUMMARY = 8'hF0;

  typedef struct packed {
    logic run;
    logic nodesc;
    logic stop_ie;
  } ctrl_t;

  typedef struct packed {
    logic end_f;
    logic start_f;
    logic berr_f;
  } flags_t;

  // Sticky flag update: a new event beats a clearing write.
  function automatic logic sticky_next(logic cur, logic clr, logic set);
    return set | (cur & ~clr);
  endfunction

  function automatic logic chan_cause(flags_t f, logic end_ie, logic start_ie,
                                      logic stopped, logic stop_ie);
    return (f.end_f & end_ie) | (f.start_f & start_ie) | f.berr_f |
           (stopped & stop_ie);
  endfunction

  function automatic logic [31:0] pack_word(ctrl_t c, flags_t f,
                                            logic reqpend, logic stopped);
    logic [31:0] w;
    w              = '0;
    w[BIT_RUN]     = c.run;
    w[BIT_NODESC]  = c.nodesc;
    w[BIT_STOPIE]  = c.stop_ie;
    w[BIT_REQPEND] = reqpend;
    w[BIT_STOPPED] = stopped;
    w[BIT_END]     = f.end_f;
    w[BIT_START]   = f.start_f;
    w[BIT_BERR]    = f.berr_f;
    return w;
  endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic [NUM_CH-1:0] chan_hit,
  output logic [NUM_CH-1:0] chan_wr,
  output logic              align_hit,
  output logic              align_wr,
  output logic              summary_hit
);
  import dma_csr_pkg::*;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign chan_hit[i] = (addr == ADDR_W'(i * 4));
    assign chan_wr[i]  = wr & chan_hit[i];
  end

  assign align_hit   = (addr == ADDR_W'(OFS_ALIGN));
  assign align_wr    = wr & align_hit;
  assign summary_hit = (addr == ADDR_W'(OFS_SUMMARY));

endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_sel,
  input  logic [31:0]         wdata,
  input  logic                ev_start,
  input  logic                ev_end,
  input  logic                ev_berr,
  output dma_csr_pkg::ctrl_t  ctrl_o,
  output dma_csr_pkg::flags_t flags_o
);
  import dma_csr_pkg::*;

  logic clr_end, clr_start, clr_berr;

  assign clr_end   = wr_sel & wdata[BIT_END];
  assign clr_start = wr_sel & wdata[BIT_START];
  assign clr_berr  = wr_sel & wdata[BIT_BERR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_o  <= '0;
      flags_o <= '0;
    end else begin
      if (wr_sel) begin
        ctrl_o.run     <= wdata[BIT_RUN];
        ctrl_o.nodesc  <= wdata[BIT_NODESC];
        ctrl_o.stop_ie <= wdata[BIT_STOPIE];
      end
      flags_o.end_f   <= sticky_next(flags_o.end_f,   clr_end,   ev_end);
      flags_o.start_f <= sticky_next(flags_o.start_f, clr_start, ev_start);
      flags_o.berr_f  <= sticky_next(flags_o.berr_f,  clr_berr,  ev_berr);
    end
  end

endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] end_v,
  input  logic [NUM_CH-1:0] start_v,
  input  logic [NUM_CH-1:0] berr_v,
  input  logic [NUM_CH-1:0] stop_ie_v,
  input  logic [NUM_CH-1:0] end_ie,
  input  logic [NUM_CH-1:0] start_ie,
  input  logic [NUM_CH-1:0] stopped,
  output logic [NUM_CH-1:0] summary,
  output logic              irq_q
);
  import dma_csr_pkg::*;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cause
    flags_t f;
    assign f          = '{end_f: end_v[i], start_f: start_v[i], berr_f: berr_v[i]};
    assign summary[i] = chan_cause(f, end_ie[i], start_ie[i], stopped[i], stop_ie_v[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |summary;
  end

endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] ev_start,
  input  logic [NUM_CH-1:0] ev_end,
  input  logic [NUM_CH-1:0] ev_berr,
  input  logic [NUM_CH-1:0] desc_start_ie,
  input  logic [NUM_CH-1:0] desc_end_ie,
  input  logic [NUM_CH-1:0] eng_stopped,
  input  logic [NUM_CH-1:0] eng_req,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] nodesc_o,
  output logic [NUM_CH-1:0] byte_align_o,
  output logic              irq_o
);
  import dma_csr_pkg::*;

  logic [NUM_CH-1:0] chan_hit, chan_wr;
  logic              align_hit, align_wr, summary_hit;
  logic [NUM_CH-1:0] end_v, start_v, berr_v, stop_ie_v;
  logic [NUM_CH-1:0] summary;
  logic [NUM_CH-1:0] align_q;
  logic [31:0]       chan_word [NUM_CH];

  dma_csr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr        (reg_addr),
    .wr          (reg_wr),
    .chan_hit    (chan_hit),
    .chan_wr     (chan_wr),
    .align_hit   (align_hit),
    .align_wr    (align_wr),
    .summary_hit (summary_hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ctrl_t  c;
    flags_t f;
    dma_csr_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (chan_wr[i]),
      .wdata    (reg_wdata),
      .ev_start (ev_start[i]),
      .ev_end   (ev_end[i]),
      .ev_berr  (ev_berr[i]),
      .ctrl_o   (c),
      .flags_o  (f)
    );
    assign run_o[i]     = c.run;
    assign nodesc_o[i]  = c.nodesc;
    assign stop_ie_v[i] = c.stop_ie;
    assign end_v[i]     = f.end_f;
    assign start_v[i]   = f.start_f;
    assign berr_v[i]    = f.berr_f;
    assign chan_word[i] = pack_word(c, f, eng_req[i], eng_stopped[i]);
  end

  dma_csr_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_v     (end_v),
    .start_v   (start_v),
    .berr_v    (berr_v),
    .stop_ie_v (stop_ie_v),
    .end_ie    (desc_end_ie),
    .start_ie  (desc_start_ie),
    .stopped   (eng_stopped),
    .summary   (summary),
    .irq_q     (irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        align_q <= '0;
    else if (align_wr) align_q <= reg_wdata[NUM_CH-1:0];
  end
  assign byte_align_o = align_q;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (chan_hit[i]) reg_rdata = chan_word[i];
    if (align_hit)   reg_rdata = 32'(align_q);
    if (summary_hit) reg_rdata = 32'(summary);
  end

endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       reg_wdata,
  input logic [NUM_CH-1:0] chan_wr,
  input logic [NUM_CH-1:0] ev_end,
  input logic [NUM_CH-1:0] ev_start,
  input logic [NUM_CH-1:0] ev_berr,
  input logic [NUM_CH-1:0] end_v,
  input logic [NUM_CH-1:0] start_v,
  input logic [NUM_CH-1:0] berr_v,
  input logic [NUM_CH-1:0] run_o,
  input logic [NUM_CH-1:0] summary,
  input logic              irq_o
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2
    a_r2_run_load: assert property (@(posedge clk) disable iff (!rst_n)
      chan_wr[i] |=> (run_o[i] == $past(reg_wdata[31])));
    // R4
    a_r4_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (end_v[i] && !(chan_wr[i] && reg_wdata[2])) |=> end_v[i]);
    // R5
    a_r5_berr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_wr[i] && reg_wdata[0] && !ev_berr[i]) |=> !berr_v[i]);
    // R6
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start[i] |=> start_v[i]);
  end

  // R8
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|summary) |=> irq_o);
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|summary) |=> !irq_o);

endmodule

bind dma_csr_bank dma_csr_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wdata (reg_wdata),
  .chan_wr   (chan_wr),
  .ev_end    (ev_end),
  .ev_start  (ev_start),
  .ev_berr   (ev_berr),
  .end_v     (end_v),
  .start_v   (start_v),
  .berr_v    (berr_v),
  .run_o     (run_o),
  .summary   (summary),
  .irq_o     (irq_o)
);

// File: tb/tb_dma_csr_bank.sv
`timescale 1ns/1ps
module tb_dma_csr_bank;
  localparam int NCH = 4;
  localparam int AW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NCH-1:0]  ev_start = '0, ev_end = '0, ev_berr = '0;
  logic [NCH-1:0]  desc_start_ie = '0, desc_end_ie = '0;
  logic [NCH-1:0]  eng_stopped = '0, eng_req = '0;
  logic [NCH-1:0]  run_o, nodesc_o, byte_align_o;
  logic            irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_csr_bank #(.NUM_CH(NCH), .ADDR_W(AW)) dut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_rd(string req, logic [AW-1:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse(ref logic [NCH-1:0] sig, input int ch);
    @(negedge clk);
    sig[ch] = 1'b1;
    @(negedge clk);
    sig[ch] = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < NCH; i++) expect_rd("R1 chan word", AW'(i*4), 32'h0);
    expect_rd("R1 align", 8'hA0, 32'h0);
    expect_rd("R1 summary", 8'hF0, 32'h0);
    check("R1 irq", 32'(irq_o), 0);
    check("R1 run", 32'(run_o), 0);
  endtask

  task automatic t_ctrl();
    wr(8'h04, 32'hE000_0000);
    expect_rd("R2 ctrl readback", 8'h04, 32'hE000_0000);
    check("R2 run_o", 32'(run_o), 32'h2);
    check("R2 nodesc_o", 32'(nodesc_o), 32'h2);
    wr(8'h04, 32'h2000_0000);
    check("R2 run cleared", 32'(run_o), 32'h0);
    expect_rd("R2 stop_ie kept", 8'h04, 32'h2000_0000);
    wr(8'h0C, 32'h1FFF_FEF0);
    expect_rd("R3 unused bits zero", 8'h0C, 32'h0);
  endtask

  task automatic t_live();
    @(negedge clk);
    eng_req[2] = 1'b1; eng_stopped[2] = 1'b1;
    expect_rd("R3 live req/stopped", 8'h08, 32'h0000_0108);
    expect_rd("R7 stopped w/o enable", 8'hF0, 32'h0);
    eng_req[2] = 1'b0; eng_stopped[2] = 1'b0;
  endtask

  task automatic t_events();
    pulse(ev_end, 0);
    pulse(ev_berr, 0);
    expect_rd("R4 flags set", 8'h00, 32'h5);
    repeat (3) @(negedge clk);
    expect_rd("R4 flags sticky", 8'h00, 32'h5);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(8'h00, 32'h1);
    expect_rd("R5 berr cleared only", 8'h00, 32'h4);
    wr(8'h00, 32'h8000_0000);
    expect_rd("R5 zero write keeps flag", 8'h00, 32'h8000_0004);
    pulse(ev_start, 0);
    rd(8'h00, v);
    check("R4 start flag", v, 32'h8000_0006);
    wr(8'h00, v);
    expect_rd("R5 rmw clears flags keeps ctrl", 8'h00, 32'h8000_0000);
    check("R5 run kept", 32'(run_o), 32'h1);
  endtask

  task automatic t_collide();
    @(negedge clk);
    reg_addr = 8'h00; reg_wdata = 32'h8000_0004; reg_wr = 1'b1; ev_end[0] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_end[0] = 1'b0;
    expect_rd("R6 event wins", 8'h00, 32'h8000_0004);
    wr(8'h00, 32'h8000_0004);
    expect_rd("R6 later clear", 8'h00, 32'h8000_0000);
  endtask

  task automatic t_irq();
    check("R8 idle irq", 32'(irq_o), 0);
    desc_end_ie[3] = 1'b1;
    pulse(ev_end, 3);
    expect_rd("R7 end enabled", 8'hF0, 32'h8);
    check("R8 irq not yet", 32'(irq_o), 0);
    @(negedge clk);
    check("R8 irq one cycle later", 32'(irq_o), 1);
    wr(8'h0C, 32'h4);
    expect_rd("R7 cleared", 8'hF0, 32'h0);
    check("R8 irq still high", 32'(irq_o), 1);
    @(negedge clk);
    check("R8 irq falls", 32'(irq_o), 0);
    desc_end_ie[3] = 1'b0;

    pulse(ev_start, 2);
    @(negedge clk);
    expect_rd("R7 start masked", 8'hF0, 32'h0);
    check("R8 no irq masked", 32'(irq_o), 0);
    desc_start_ie[2] = 1'b1;
    expect_rd("R7 start enabled", 8'hF0, 32'h4);
    wr(8'h08, 32'h2);
    desc_start_ie[2] = 1'b0;

    pulse(ev_berr, 1);
    expect_rd("R7 berr always", 8'hF0, 32'h2);
    wr(8'hF0, 32'hFFFF_FFFF);
    expect_rd("R7 summary write ignored", 8'hF0, 32'h2);
    expect_rd("R7 berr flag kept", 8'h04, 32'h2000_0001);
    wr(8'h04, 32'h2000_0001);
    expect_rd("R5 berr cleared", 8'hF0, 32'h0);

    @(negedge clk);
    eng_stopped[1] = 1'b1;
    expect_rd("R7 stop enabled", 8'hF0, 32'h2);
    wr(8'h04, 32'h0);
    expect_rd("R7 stop disabled", 8'hF0, 32'h0);
    eng_stopped[1] = 1'b0;
  endtask

  task automatic t_align();
    wr(8'hA0, 32'hFFFF_FFF5);
    expect_rd("R9 align readback", 8'hA0, 32'h5);
    check("R9 byte_align_o", 32'(byte_align_o), 32'h5);
  endtask

  task automatic t_unmapped();
    wr(8'h10, 32'hFFFF_FFFF);
    expect_rd("R10 slot beyond channels", 8'h10, 32'h0);
    wr(8'h02, 32'hFFFF_FFFF);
    expect_rd("R10 misaligned read", 8'h02, 32'h0);
    expect_rd("R10 ch0 untouched", 8'h00, 32'h8000_0000);
    expect_rd("R10 other offset", 8'h80, 32'h0);
    check("R10 align untouched", 32'(byte_align_o), 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_live();
    t_events();
    t_w1c();
    t_collide();
    t_irq();
    t_align();
    t_unmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule